// File: doc/BRIEF.md
# GPIO Port Register File

This block is the word-wide control register file for a 32-pin general purpose I/O port. Software reaches it through a simple single-cycle bus: address, read strobe, write strobe, write data, and a registered read word with an error flag. It holds the output level of each pin, the direction of each pin and one configuration word per pin. All of these go as flat vectors to a separate pin resolver. The IN word is sampled from the resolver's pin levels and is read-only.

Both the output word and the direction word have three write views. One writes the whole word, one sets the bits that are 1 in the data, and one clears them. Pin direction can be seen in two places: the direction word, and bit 0 of each pin's configuration word. The block keeps these two views in step whichever register is written. Each accepted write raises a one-cycle update strobe, which tells the resolver to recompute the pin state.

A small three-state sequencer sets the response in the cycle after an access. In ST_IDLE no response is pending. ST_UPDATE follows an accepted write and drives the update strobe. ST_FAULT follows an access to an unmapped, misaligned or read-only-for-writes address and drives the error flag. The next state is chosen from the current access alone, so each state moves to ST_UPDATE on an accepted write, to ST_FAULT on a bad access, and to ST_IDLE otherwise (a clean read or no access).

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, out_val and dir_val are 0, every configuration word is 0x00000002, and neither upd_strobe nor bus_err is high.
- R2: A write to offset 0x000 replaces the output word. A write to 0x004 ORs the data into it. A write to 0x008 clears the bits that are 1 in the data. out_val shows the result in the cycle after the write, and it changes only on a write.
- R3: Reads at 0x000, 0x004 and 0x008 all return the current output word.
- R4: Offsets 0x010 (replace), 0x014 (set) and 0x018 (clear) act on the direction word by the same three rules. All three read back the direction word, and dir_val changes only on a write.
- R5: After any write to 0x010, 0x014 or 0x018, bit 0 of configuration word i equals direction bit i for every pin, and bits 31:1 of every configuration word are unchanged.
- R6: A write to 0x100 + 4*n stores the full word as configuration word n (visible at cfg_flat[32n+31:32n] and on read) and copies its bit 0 into direction bit n.
- R7: A read at 0x00C returns pin_level as sampled on a clock edge. A write to 0x00C has no effect, raises bus_err and gives no update strobe.
- R8: An access to an unmapped or non-word-aligned address, including 0x180 and above in the configuration window, raises bus_err in the next cycle. Such a read returns 0 and such a write changes no state.
- R9: Every accepted write raises upd_strobe for exactly the next cycle, including back-to-back writes. upd_strobe is never high in a cycle that does not follow an accepted write.
- R10: Read data appears on bus_rdata in the cycle after bus_rd and shows the state before any write issued in the same cycle. bus_rdata is 0 in a cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_rd | input | 1 | Read request this cycle |
| bus_wr | input | 1 | Write request this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| bus_err | output | 1 | Access error, one cycle after the access |
| pin_level | input | 32 | Pin levels from the resolver, sampled into IN |
| out_val | output | 32 | Output word to the resolver |
| dir_val | output | 32 | Direction word to the resolver (1 = output) |
| cfg_flat | output | 1024 | Configuration words, pin n at bits 32n+31:32n |
| upd_strobe | output | 1 | One-cycle request to recompute pin state |

## Verification
Two events can share a cycle: a read and a write can hit the same register, and a write can land while the strobe from the previous write is still high. The bench issues a combined read and write to the output word and expects the read to return the old value while out_val takes the new one. It also issues back-to-back writes and expects the strobe to stay high once for each write. A reference model in the bench predicts every read word, error and strobe. A direction write that follows configuration writes shows whether the coherence rule kept the upper configuration bits intact.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;

    // Word offsets of the register views (byte addresses)
    localparam int unsigned OFS_OUT    = 'h000;
    localparam int unsigned OFS_OUTSET = 'h004;
    localparam int unsigned OFS_OUTCLR = 'h008;
    localparam int unsigned OFS_IN     = 'h00C;
    localparam int unsigned OFS_DIR    = 'h010;
    localparam int unsigned OFS_DIRSET = 'h014;
    localparam int unsigned OFS_DIRCLR = 'h018;

    // Reset value of a configuration word: input buffer detached
    localparam logic [31:0] CFG_RESET = 32'h0000_0002;

    typedef enum logic [3:0] {
        RG_OUT,
        RG_OUTSET,
        RG_OUTCLR,
        RG_IN,
        RG_DIR,
        RG_DIRSET,
        RG_DIRCLR,
        RG_CFG,
        RG_NONE
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_UPDATE,
        ST_FAULT
    } resp_state_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_regs_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int PINS     = 32,
    parameter int CFG_BASE = 'h100,
    localparam int IDX_W   = (PINS > 1) ? $clog2(PINS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  cfg_idx
);

    localparam int CFG_SPAN = 4 * PINS;

    logic [ADDR_W-1:0] cfg_off;
    logic              in_cfg;

    always_comb begin
        cfg_off = addr - ADDR_W'(CFG_BASE);
        in_cfg  = (int'(addr) >= CFG_BASE) && (int'(cfg_off) < CFG_SPAN);
        cfg_idx = IDX_W'(cfg_off >> 2);
    end

    always_comb begin
        region = RG_NONE;
        if (addr[1:0] == 2'b00) begin
            if (in_cfg) begin
                region = RG_CFG;
            end else begin
                unique case (int'(addr))
                    OFS_OUT:    region = RG_OUT;
                    OFS_OUTSET: region = RG_OUTSET;
                    OFS_OUTCLR: region = RG_OUTCLR;
                    OFS_IN:     region = RG_IN;
                    OFS_DIR:    region = RG_DIR;
                    OFS_DIRSET: region = RG_DIRSET;
                    OFS_DIRCLR: region = RG_DIRCLR;
                    default:    region = RG_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
    import gpio_regs_pkg::*;
#(
    parameter int PINS   = 32,
    parameter int DATA_W = 32,
    localparam int IDX_W = (PINS > 1) ? $clog2(PINS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  region_e                region,
    input  logic [IDX_W-1:0]       cfg_idx,
    input  logic [DATA_W-1:0]      wdata,
    output logic [PINS-1:0]        dir_q,
    output logic [PINS*DATA_W-1:0] cfg_flat
);

    // Direction is stored once; bit 0 of each config word is a view of it.
    logic [PINS-1:0] dir_next;

    always_comb begin
        dir_next = dir_q;
        if (wr_en) begin
            unique case (region)
                RG_DIR:    dir_next = wdata[PINS-1:0];
                RG_DIRSET: dir_next = dir_q | wdata[PINS-1:0];
                RG_DIRCLR: dir_next = dir_q & ~wdata[PINS-1:0];
                RG_CFG:    dir_next[cfg_idx] = wdata[0];
                default:   dir_next = dir_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dir_q <= '0;
        else        dir_q <= dir_next;
    end

    for (genvar n = 0; n < PINS; n++) begin : g_pin
        logic [DATA_W-1:1] hi_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hi_q <= CFG_RESET[DATA_W-1:1];
            end else if (wr_en && region == RG_CFG && cfg_idx == IDX_W'(n)) begin
                hi_q <= wdata[DATA_W-1:1];
            end
        end

        assign cfg_flat[n*DATA_W +: DATA_W] = {hi_q, dir_q[n]};
    end

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_regs_pkg::*;
#(
    parameter int PINS   = 32,
    parameter int DATA_W = 32,
    localparam int IDX_W = (PINS > 1) ? $clog2(PINS) : 1
) (
    input  region_e                region,
    input  logic [IDX_W-1:0]       cfg_idx,
    input  logic [PINS-1:0]        out_q,
    input  logic [PINS-1:0]        in_q,
    input  logic [PINS-1:0]        dir_q,
    input  logic [PINS*DATA_W-1:0] cfg_flat,
    output logic [DATA_W-1:0]      rd_word
);

    logic [DATA_W-1:0] cfg_word;

    always_comb begin
        cfg_word = '0;
        for (int n = 0; n < PINS; n++) begin
            if (cfg_idx == IDX_W'(n)) cfg_word = cfg_flat[n*DATA_W +: DATA_W];
        end
    end

    always_comb begin
        unique case (region)
            RG_OUT, RG_OUTSET, RG_OUTCLR: rd_word = DATA_W'(out_q);
            RG_IN:                        rd_word = DATA_W'(in_q);
            RG_DIR, RG_DIRSET, RG_DIRCLR: rd_word = DATA_W'(dir_q);
            RG_CFG:                       rd_word = cfg_word;
            default:                      rd_word = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_regs_pkg::*;
#(
    parameter int PINS     = 32,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 12,
    parameter int CFG_BASE = 'h100
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_rd,
    input  logic                   bus_wr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic                   bus_err,
    input  logic [PINS-1:0]        pin_level,
    output logic [PINS-1:0]        out_val,
    output logic [PINS-1:0]        dir_val,
    output logic [PINS*DATA_W-1:0] cfg_flat,
    output logic                   upd_strobe
);

    localparam int IDX_W = (PINS > 1) ? $clog2(PINS) : 1;

    region_e           region;
    logic [IDX_W-1:0]  cfg_idx;
    logic [DATA_W-1:0] rd_word;
    logic [PINS-1:0]   out_q;
    logic [PINS-1:0]   in_q;
    logic              bad_acc;
    logic              wr_ok;
    resp_state_e       state_q;
    resp_state_e       state_d;

    gpio_addr_decode #(
        .ADDR_W(ADDR_W), .PINS(PINS), .CFG_BASE(CFG_BASE)
    ) u_dec (
        .addr(bus_addr), .region(region), .cfg_idx(cfg_idx)
    );

    always_comb begin
        bad_acc = (bus_rd || bus_wr) &&
                  (region == RG_NONE || (bus_wr && region == RG_IN));
        wr_ok   = bus_wr && !bad_acc;
    end

    gpio_cfg_bank #(
        .PINS(PINS), .DATA_W(DATA_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .region(region),
        .cfg_idx(cfg_idx), .wdata(bus_wdata), .dir_q(dir_val),
        .cfg_flat(cfg_flat)
    );

    gpio_read_mux #(
        .PINS(PINS), .DATA_W(DATA_W)
    ) u_rmux (
        .region(region), .cfg_idx(cfg_idx), .out_q(out_q), .in_q(in_q),
        .dir_q(dir_val), .cfg_flat(cfg_flat), .rd_word(rd_word)
    );

    // Output word with its three write views
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (wr_ok) begin
            unique case (region)
                RG_OUT:    out_q <= bus_wdata[PINS-1:0];
                RG_OUTSET: out_q <= out_q | bus_wdata[PINS-1:0];
                RG_OUTCLR: out_q <= out_q & ~bus_wdata[PINS-1:0];
                default:   out_q <= out_q;
            endcase
        end
    end

    assign out_val = out_q;

    // Pin sampling and registered read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q      <= '0;
            bus_rdata <= '0;
        end else begin
            in_q      <= pin_level;
            bus_rdata <= (bus_rd && !bad_acc) ? rd_word : '0;
        end
    end

    // Response sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Response sequencer: next state, same for every current state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_UPDATE, ST_FAULT: begin
                if (bad_acc)    state_d = ST_FAULT;
                else if (wr_ok) state_d = ST_UPDATE;
                else            state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Response sequencer: outputs
    always_comb begin
        upd_strobe = 1'b0;
        bus_err    = 1'b0;
        unique case (state_q)
            ST_UPDATE: upd_strobe = 1'b1;
            ST_FAULT:  bus_err    = 1'b1;
            default: begin
                upd_strobe = 1'b0;
                bus_err    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
    parameter int PINS   = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_err,
    input logic [PINS-1:0]   out_val,
    input logic [PINS-1:0]   dir_val,
    input logic              upd_strobe
);

    // R9
    write_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> (upd_strobe ^ bus_err));

    // R9
    no_stray_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> !upd_strobe);

    // R8
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == '0));

    // R8
    idle_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd || bus_wr) |=> !bus_err);

    // R2
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(out_val));

    // R4
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(dir_val));

    // R10
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

endmodule

bind gpio_port_regs gpio_port_regs_chk #(
    .PINS(PINS), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .out_val(out_val),
    .dir_val(dir_val), .upd_strobe(upd_strobe)
);

// File: tb/gpio_port_regs_test.sv
module gpio_port_regs_test;

    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_err;
    logic [31:0]   pin_level = '0;
    logic [31:0]   out_val;
    logic [31:0]   dir_val;
    logic [1023:0] cfg_flat;
    logic          upd_strobe;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .pin_level(pin_level), .out_val(out_val),
        .dir_val(dir_val), .cfg_flat(cfg_flat), .upd_strobe(upd_strobe)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Reference model
    logic [31:0] m_out = '0;
    logic [31:0] m_dir = '0;
    logic [31:0] m_in  = '0;
    logic [31:0] m_cfg [32];

    // Scoreboard queues
    logic [31:0] q_rd  [$];
    logic        q_err [$];
    logic        q_stb [$];
    string       q_tag [$];
    logic        launched_q = 1'b0;

    function automatic int kind_of(logic [11:0] a);
        if (a[1:0] != 2'b00) return 8;
        if (a >= 12'h100 && a < 12'h180) return 7;
        case (a)
            12'h000: return 0;
            12'h004: return 1;
            12'h008: return 2;
            12'h00C: return 3;
            12'h010: return 4;
            12'h014: return 5;
            12'h018: return 6;
            default: return 8;
        endcase
    endfunction

    function automatic logic [31:0] cfg_of(int n);
        return cfg_flat[n*32 +: 32];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic rd, input logic wr, input logic [11:0] a,
                       input logic [31:0] wd, input string tag);
        int k;
        int idx;
        logic bad_a;
        logic [31:0] exp_rd;
        k = kind_of(a);
        idx = int'((a - 12'h100) >> 2);
        bad_a = (k == 8) || (wr && k == 3);
        exp_rd = '0;
        if (rd && !bad_a) begin
            case (k)
                0, 1, 2: exp_rd = m_out;
                3:       exp_rd = m_in;
                4, 5, 6: exp_rd = m_dir;
                default: exp_rd = m_cfg[idx];
            endcase
        end
        if (wr && !bad_a) begin
            case (k)
                0: m_out = wd;
                1: m_out = m_out | wd;
                2: m_out = m_out & ~wd;
                4: m_dir = wd;
                5: m_dir = m_dir | wd;
                6: m_dir = m_dir & ~wd;
                7: begin m_cfg[idx] = wd; m_dir[idx] = wd[0]; end
                default: ;
            endcase
            if (k >= 4 && k <= 6)
                for (int i = 0; i < 32; i++) m_cfg[i][0] = m_dir[i];
        end
        q_rd.push_back(exp_rd);
        q_err.push_back(bad_a);
        q_stb.push_back(wr && !bad_a);
        q_tag.push_back(tag);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        for (int i = 1; i < n; i++) @(negedge clk);
    endtask

    task automatic check_model_ports(input string tag);
        chk({tag, " out_val"}, out_val, m_out);
        chk({tag, " dir_val"}, dir_val, m_dir);
        for (int i = 0; i < 32; i++)
            if (cfg_of(i) !== m_cfg[i]) chk({tag, " cfg word"}, cfg_of(i), m_cfg[i]);
        total++;
    endtask

    // Monitor: compare each response one cycle after its access
    always @(posedge clk) launched_q <= rst_n && (bus_rd || bus_wr);

    initial begin
        forever begin
            @(negedge clk);
            if (launched_q) begin
                if (q_rd.size() == 0) begin
                    chk("R10 unexpected response", 32'h1, 32'h0);
                end else begin
                    logic [31:0] e_rd;
                    logic e_err, e_stb;
                    string t;
                    e_rd = q_rd.pop_front();
                    e_err = q_err.pop_front();
                    e_stb = q_stb.pop_front();
                    t = q_tag.pop_front();
                    chk({t, " rdata"}, bus_rdata, e_rd);
                    chk({t, " err"}, {31'b0, bus_err}, {31'b0, e_err});
                    chk({t, " strobe"}, {31'b0, upd_strobe}, {31'b0, e_stb});
                end
            end else if (rst_n) begin
                // R9: quiet cycles carry no strobe and no error
                chk("R9 quiet strobe", {31'b0, upd_strobe}, 32'h0);
                chk("R8 quiet err", {31'b0, bus_err}, 32'h0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) m_cfg[i] = 32'h0000_0002;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 out_val", out_val, 32'h0);
        chk("R1 dir_val", dir_val, 32'h0);
        for (int i = 0; i < 32; i++) chk("R1 cfg reset", cfg_of(i), 32'h0000_0002);
        chk("R1 strobe", {31'b0, upd_strobe}, 32'h0);
        acc(1, 0, 12'h00C, 0, "R1 R7 IN after reset");
        acc(1, 0, 12'h104, 0, "R1 cfg read pin1");

        // R2 R3 output word views
        acc(0, 1, 12'h000, 32'hA5A5_0F0F, "R2 OUT write");
        acc(1, 0, 12'h000, 0, "R3 read OUT");
        acc(0, 1, 12'h004, 32'h0000_F000, "R2 OUTSET");
        acc(1, 0, 12'h004, 0, "R3 read via OUTSET");
        acc(0, 1, 12'h008, 32'hA000_000F, "R2 OUTCLR");
        acc(1, 0, 12'h008, 0, "R3 read via OUTCLR");
        idle(1);
        chk("R2 out_val", out_val, 32'h05A5_FF00);

        // R4 R5 direction views and coherence
        acc(0, 1, 12'h010, 32'h0000_00FF, "R4 DIR write");
        acc(0, 1, 12'h014, 32'h8000_0000, "R4 DIRSET");
        acc(0, 1, 12'h018, 32'h0000_0001, "R4 DIRCLR");
        acc(1, 0, 12'h018, 0, "R4 read via DIRCLR");
        acc(1, 0, 12'h014, 0, "R4 read via DIRSET");
        idle(1);
        chk("R4 dir_val", dir_val, 32'h8000_00FE);
        chk("R5 cfg pin0", cfg_of(0), 32'h0000_0002);
        chk("R5 cfg pin1", cfg_of(1), 32'h0000_0003);
        chk("R5 cfg pin31", cfg_of(31), 32'h0000_0003);
        check_model_ports("R5 model");

        // R6 configuration writes feed direction
        acc(0, 1, 12'h114, 32'h0000_070C, "R6 cfg pin5 write");
        acc(0, 1, 12'h150, 32'h0000_0301, "R6 cfg pin20 write");
        acc(1, 0, 12'h114, 0, "R6 cfg pin5 read");
        acc(1, 0, 12'h010, 0, "R6 DIR readback");
        idle(1);
        chk("R6 dir_val", dir_val, 32'h8010_00DE);
        chk("R6 cfg pin20 port", cfg_of(20), 32'h0000_0301);

        // R5 direction write keeps upper config bits
        acc(0, 1, 12'h010, 32'h0000_0000, "R5 DIR clear all");
        acc(1, 0, 12'h150, 0, "R5 cfg pin20 after DIR");
        idle(1);
        chk("R5 cfg pin5 port", cfg_of(5), 32'h0000_070C);
        chk("R5 cfg pin20 port", cfg_of(20), 32'h0000_0300);
        check_model_ports("R5 R6 model");

        // R7 input sampling and write protection
        pin_level = 32'h1234_5678; m_in = 32'h1234_5678;
        idle(3);
        acc(1, 0, 12'h00C, 0, "R7 IN read");
        acc(0, 1, 12'h00C, 32'hFFFF_FFFF, "R7 IN write rejected");
        acc(1, 0, 12'h00C, 0, "R7 IN after write");
        idle(1);
        check_model_ports("R7 no side effect");

        // R8 unmapped, misaligned, past end
        acc(1, 0, 12'h040, 0, "R8 unmapped read");
        acc(0, 1, 12'h002, 32'hFFFF_FFFF, "R8 misaligned write");
        acc(0, 1, 12'h180, 32'h0000_0001, "R8 past cfg end write");
        acc(1, 0, 12'h17C, 0, "R8 last cfg read");
        idle(1);
        check_model_ports("R8 no side effect");

        // R10 read and write to same register in one cycle
        acc(1, 1, 12'h000, 32'h0000_00AA, "R10 same-cycle rd/wr");
        idle(1);
        chk("R10 out_val after", out_val, 32'h0000_00AA);

        // R9 back-to-back writes, each with its own strobe
        acc(0, 1, 12'h004, 32'h0000_0100, "R9 b2b 1");
        acc(0, 1, 12'h014, 32'h0000_0002, "R9 b2b 2");
        acc(0, 1, 12'h108, 32'h0000_0005, "R9 b2b 3");
        acc(1, 0, 12'h014, 0, "R9 b2b read dir");
        idle(2);
        check_model_ports("R9 model");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule